// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Target

This block is a receive-only target for a two-wire serial bus. It watches the clock line and the data line as ordinary inputs, sampled on a faster system clock. Both lines go through a two-flop synchronizer and then a three-sample majority filter. The block never starts a transfer and never sends data. Its one bus output is an acknowledge pulldown enable on a pin of its own, apart from the data input. A board can wire that pin to the data line, or it can leave the acknowledge unseen, and reception works the same either way.

A transfer starts with a START condition, followed by an address byte. The address byte must hold the block's 7-bit address and a write direction bit. The next byte is a device-select command. Its low three bits are compared with the hardware subaddress straps. Any number of data bytes may follow until a STOP or a repeated START. Every byte of an addressed transfer is acknowledged. Bytes go to the downstream logic on a one-cycle strobe, and only while the subaddress matches. The command byte itself is delivered with a first-byte flag.

Top module: `i2c_wr_target`

## Requirements
- R1: A START (data falls while the clock is high) begins a new address phase. A STOP (data rises while the clock is high) returns the block to idle and releases the acknowledge output within 8 system clocks. Out of reset, `ackPull` and `byteValid` are 0.
- R2: Exactly one data bit is captured on each rising clock edge, most significant bit first. A data change while the clock is low is never taken as a bit.
- R3: When the block is addressed, `ackPull` rises after the falling clock edge that ends the 8th bit. It stays 1 through the whole high period of the 9th clock and returns to 0 after the falling edge that ends that clock. Reception does not depend on the acknowledge being visible on the data line.
- R4: Any number of bytes in one transfer are each acknowledged and delivered. A transfer of 6 bytes after the address is handled in full.
- R5: If the address byte's upper 7 bits differ from `SLAVE_ADDR`, or its last bit is 1 (read), there is no acknowledge. No byte is acknowledged or delivered after that until the next START.
- R6: Bits [2:0] of the command byte (the first byte after the address) are compared with `subAddr`. On a match, the command byte is delivered with `firstByte` = 1.
- R7: Data bytes after the command byte are delivered with `firstByte` = 0, and only when the command matched. A non-matching command and its data bytes are still acknowledged but never delivered.
- R8: A clock-line glitch one system clock long is rejected by the majority filter and does not add or remove a bit.
- R9: A STOP or START in the middle of a byte throws that byte away without delivering it.
- R10: A repeated START without a STOP begins a new address and command phase, and the subaddress decision is made again for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line, sampled asynchronously |
| sda | input | 1 | Bus data line, sampled asynchronously |
| subAddr | input | 3 | Hardware subaddress straps |
| ackPull | output | 1 | 1 = pull the data line low to acknowledge |
| byteData | output | 8 | Received byte, valid with byteValid |
| byteValid | output | 1 | One-cycle strobe for a delivered byte |
| firstByte | output | 1 | Marks the command byte right after the address |

## Verification
The assertions assume the filtered clock and data lines never change in the same system clock. They also assume delivered bytes are spaced far apart compared with the filter latency, because a bus bit lasts many system clocks. The stimulus holds every clock half-period at 16 system clocks. It moves the data line only while the clock is low, except when it means to make a START or a STOP. Its single glitches land well inside a half-period, so the filter window never sees two disturbed samples.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKING,
    ST_SKIP
  } ctlState_t;

  typedef enum logic [1:0] {
    KIND_ADDR,
    KIND_CMD,
    KIND_DATA
  } byteKind_t;

  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic setSel;
    logic clrSel;
    logic emit;
    logic emitFirst;
  } ctlStrobes_t;

endpackage

// File: rtl/i2cw_frontend.sv
module i2cw_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sda,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int LINES    = 2;
  localparam int MAJ_NEED = FILT_TAPS / 2 + 1;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] filtNow;
  logic [LINES-1:0] filtPrev;

  assign rawIn = {sda, scl};

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    logic [SYNC_STAGES-1:0] syncPipe;
    logic [FILT_TAPS-1:0]   window;
    logic                   majVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncPipe <= '1;
        window   <= '1;
      end else begin
        syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawIn[ln]};
        window   <= {window[FILT_TAPS-2:0], syncPipe[SYNC_STAGES-1]};
      end
    end

    always_comb begin
      int ones;
      ones = 0;
      for (int t = 0; t < FILT_TAPS; t++) begin
        ones = ones + int'(window[t]);
      end
      majVal = (ones >= MAJ_NEED);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filtNow[ln]  <= 1'b1;
        filtPrev[ln] <= 1'b1;
      end else begin
        filtNow[ln]  <= majVal;
        filtPrev[ln] <= filtNow[ln];
      end
    end
  end

  assign sclLevel = filtNow[0];
  assign sdaLevel = filtNow[1];
  assign sclRise  = filtNow[0] & ~filtPrev[0];
  assign sclFall  = ~filtNow[0] & filtPrev[0];
  assign startEv  = filtNow[0] & filtPrev[0] & filtPrev[1] & ~filtNow[1];
  assign stopEv   = filtNow[0] & filtPrev[0] & ~filtPrev[1] & filtNow[1];

endmodule

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int           BYTE_BITS  = 8,
  parameter int           ADDR_W     = 7,
  parameter int           SUB_W      = 3,
  parameter logic [6:0]   SLAVE_ADDR = 7'h3A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic                 sdaBit,
  input  logic [SUB_W-1:0]     subAddr,
  output logic                 byteDone,
  output logic                 addrHit,
  output logic                 subHit,
  output logic                 selMatch,
  output logic [BYTE_BITS-1:0] byteData,
  output logic                 byteValid,
  output logic                 firstByte
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

  logic [BYTE_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.clrBits) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaBit};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selMatch <= 1'b0;
    end else if (strb.clrSel) begin
      selMatch <= 1'b0;
    end else if (strb.setSel) begin
      selMatch <= subHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteData  <= '0;
      byteValid <= 1'b0;
      firstByte <= 1'b0;
    end else begin
      byteValid <= strb.emit;
      if (strb.emit) begin
        byteData  <= shiftReg;
        firstByte <= strb.emitFirst;
      end
    end
  end

  assign byteDone = (bitCnt == FULL_CNT);
  assign addrHit  = (shiftReg[BYTE_BITS-1 -: ADDR_W] == SLAVE_ADDR[ADDR_W-1:0])
                    && !shiftReg[0];
  assign subHit   = (shiftReg[SUB_W-1:0] == subAddr);

endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        byteDone,
  input  logic        addrHit,
  input  logic        subHit,
  input  logic        selMatch,
  output ctlStrobes_t strb,
  output logic        ackPull
);

  ctlState_t stateQ, stateD;
  byteKind_t kindQ, kindD;
  logic      ackQ, ackD;

  always_comb begin
    stateD = stateQ;
    kindD  = kindQ;
    ackD   = ackQ;
    strb   = '0;
    if (startEv) begin
      stateD       = ST_RECV;
      kindD        = KIND_ADDR;
      ackD         = 1'b0;
      strb.clrBits = 1'b1;
      strb.clrSel  = 1'b1;
    end else if (stopEv) begin
      stateD       = ST_IDLE;
      ackD         = 1'b0;
      strb.clrBits = 1'b1;
      strb.clrSel  = 1'b1;
    end else begin
      unique case (stateQ)
        ST_RECV: begin
          if (sclRise && !byteDone) begin
            strb.shiftIn = 1'b1;
          end else if (sclFall && byteDone) begin
            unique case (kindQ)
              KIND_ADDR: begin
                if (addrHit) begin
                  stateD = ST_ACKING;
                  ackD   = 1'b1;
                end else begin
                  stateD = ST_SKIP;
                end
              end
              KIND_CMD: begin
                stateD         = ST_ACKING;
                ackD           = 1'b1;
                strb.setSel    = 1'b1;
                strb.emit      = subHit;
                strb.emitFirst = 1'b1;
              end
              default: begin
                stateD    = ST_ACKING;
                ackD      = 1'b1;
                strb.emit = selMatch;
              end
            endcase
          end
        end
        ST_ACKING: begin
          if (sclFall) begin
            stateD       = ST_RECV;
            ackD         = 1'b0;
            strb.clrBits = 1'b1;
            kindD        = (kindQ == KIND_ADDR) ? KIND_CMD : KIND_DATA;
          end
        end
        default: begin
          ackD = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= KIND_ADDR;
      ackQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
      ackQ   <= ackD;
    end
  end

  assign ackPull = ackQ;

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2cw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h3A,
  parameter int         BYTE_BITS  = 8,
  parameter int         SUB_W      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scl,
  input  logic                 sda,
  input  logic [SUB_W-1:0]     subAddr,
  output logic                 ackPull,
  output logic [BYTE_BITS-1:0] byteData,
  output logic                 byteValid,
  output logic                 firstByte
);

  logic        sclLevel, sdaLevel;
  logic        sclRiseEv, sclFallEv, startEv, stopEv;
  logic        byteDone, addrHit, subHit, selMatch;
  ctlStrobes_t strb;

  i2cw_frontend #(
    .SYNC_STAGES(2),
    .FILT_TAPS  (3)
  ) u_front (
    .clk     (clk),
    .rstN    (rstN),
    .scl     (scl),
    .sda     (sda),
    .sclLevel(sclLevel),
    .sdaLevel(sdaLevel),
    .sclRise (sclRiseEv),
    .sclFall (sclFallEv),
    .startEv (startEv),
    .stopEv  (stopEv)
  );

  i2cw_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .sclRise (sclRiseEv),
    .sclFall (sclFallEv),
    .startEv (startEv),
    .stopEv  (stopEv),
    .byteDone(byteDone),
    .addrHit (addrHit),
    .subHit  (subHit),
    .selMatch(selMatch),
    .strb    (strb),
    .ackPull (ackPull)
  );

  i2cw_datapath #(
    .BYTE_BITS (BYTE_BITS),
    .ADDR_W    (7),
    .SUB_W     (SUB_W),
    .SLAVE_ADDR(SLAVE_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdaBit   (sdaLevel),
    .subAddr  (subAddr),
    .byteDone (byteDone),
    .addrHit  (addrHit),
    .subHit   (subHit),
    .selMatch (selMatch),
    .byteData (byteData),
    .byteValid(byteValid),
    .firstByte(firstByte)
  );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
  input logic clk,
  input logic rstN,
  input logic sclLevel,
  input logic sclFallEv,
  input logic startEv,
  input logic stopEv,
  input logic ackPull,
  input logic byteValid
);

  AST_ACK_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackPull) |-> $past(sclFallEv)); // R3

  AST_ACK_HELD_IN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ackPull && sclLevel && !startEv && !stopEv) |=> ackPull); // R3

  AST_ACK_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !ackPull); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R4

  AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteValid) |-> $past(sclFallEv)); // R2

  AST_NO_VALID_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !byteValid); // R9

endmodule

bind i2c_wr_target i2cw_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclLevel (sclLevel),
  .sclFallEv(sclFallEv),
  .startEv  (startEv),
  .stopEv   (stopEv),
  .ackPull  (ackPull),
  .byteValid(byteValid)
);

// File: tb/sim_i2c_wr_target.sv
`timescale 1ns/1ps
module sim_i2c_wr_target;

  localparam int H = 16;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam logic [2:0] STRAP = 3'd5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [2:0] subAddr = STRAP;
  logic       ackPull;
  logic [7:0] byteData;
  logic       byteValid;
  logic       firstByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [8:0] expQ[$];

  always #4 clk = ~clk;

  i2c_wr_target #(.SLAVE_ADDR(ADDR)) u0 (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda), .subAddr(subAddr),
    .ackPull(ackPull), .byteData(byteData), .byteValid(byteValid),
    .firstByte(firstByte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && byteValid) begin
      if (expQ.size() == 0) begin
        check(0, "R5 R7 R9 unexpected byte", {firstByte, byteData}, 0);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check({firstByte, byteData} == e, "R2 R6 R7 byte/first", {firstByte, byteData}, e);
      end
    end
  end

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    @(negedge clk); sda = 1'b1; waitH(H / 2);
    scl = 1'b1; waitH(H);
    sda = 1'b0; waitH(H);
    scl = 1'b0; waitH(H / 2);
  endtask

  task automatic busStop();
    @(negedge clk); sda = 1'b0; waitH(H / 2);
    scl = 1'b1; waitH(H);
    sda = 1'b1; waitH(H);
  endtask

  task automatic sendBit(input bit b, input bit glitch);
    @(negedge clk); sda = b; waitH(H / 2);
    if (glitch) begin
      scl = 1'b1; @(negedge clk); scl = 1'b0;
    end
    waitH(H / 2);
    scl = 1'b1;
    if (glitch) begin
      waitH(H / 2); scl = 1'b0; @(negedge clk); scl = 1'b1; waitH(H / 2);
    end else begin
      waitH(H);
    end
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit deliver,
                          input bit first, input string tag, input bit glitch = 0);
    for (int i = 7; i >= 0; i--) sendBit(b[i], glitch);
    if (deliver) expQ.push_back({first, b});
    @(negedge clk); sda = 1'b1; waitH(H);
    scl = 1'b1; waitH(H / 2);
    check(ackPull == expAck, {tag, " ack in 9th high"}, ackPull, expAck);
    waitH(H / 2);
    scl = 1'b0; waitH(H / 2);
    check(ackPull == 1'b0, "R3 ack released after 9th", ackPull, 0);
  endtask

  task automatic report();
    check(expQ.size() == 0, "R4 R7 missing bytes", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(ackPull == 0, "R1 reset ackPull", ackPull, 0);
    check(byteValid == 0, "R1 reset byteValid", byteValid, 0);
    rstN = 1'b1;
    waitH(10);

    // R4 R6: matched transfer, long
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R3 addr");
    sendByte(8'hF5, 1, 1, 1, "R6 cmd");
    sendByte(8'hA5, 1, 1, 0, "R4 d0");
    sendByte(8'h3C, 1, 1, 0, "R4 d1");
    sendByte(8'hFF, 1, 1, 0, "R4 d2");
    sendByte(8'h00, 1, 1, 0, "R4 d3");
    sendByte(8'h81, 1, 1, 0, "R4 d4");
    busStop();
    waitH(8);
    check(ackPull == 0, "R1 idle after stop", ackPull, 0);

    // R5: wrong address, then read bit
    busStart();
    sendByte({7'h3B, 1'b0}, 0, 0, 0, "R5 wrong addr");
    sendByte(8'hF5, 0, 0, 0, "R5 after miss");
    busStop();
    busStart();
    sendByte({ADDR, 1'b1}, 0, 0, 0, "R5 read bit");
    sendByte(8'hF5, 0, 0, 0, "R5 after read");
    busStop();

    // R7: subaddress mismatch still acked
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R7 addr");
    sendByte(8'h02, 1, 0, 0, "R7 cmd miss");
    sendByte(8'h11, 1, 0, 0, "R7 data miss");
    busStop();

    // R10: repeated start changes selection
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R10 addr");
    sendByte(8'h0D, 1, 1, 1, "R10 cmd");
    sendByte(8'h42, 1, 1, 0, "R10 data");
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R10 addr2");
    sendByte(8'h03, 1, 0, 0, "R10 cmd miss");
    sendByte(8'h77, 1, 0, 0, "R10 data dropped");
    busStop();

    // R9: abort in mid-byte
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R9 addr");
    sendByte(8'h05, 1, 1, 1, "R9 cmd");
    for (int i = 0; i < 4; i++) sendBit(1'b1, 0);
    busStop();
    waitH(8);
    check(ackPull == 0, "R9 no ack after abort", ackPull, 0);
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R9 addr2");
    sendByte(8'h05, 1, 1, 1, "R9 cmd2");
    sendByte(8'h99, 1, 1, 0, "R9 data");

    // R8: glitches on clock line
    sendByte(8'h5A, 1, 1, 0, "R8 glitch", 1);
    busStop();

    waitH(20);
    done = 1;
    report();
  end

endmodule